// File: doc/BRIEF.md
# Parallel Binary Match Array

This block is a small binary content-addressable memory. A register array holds `DEPTH` words of `WIDTH` bits, each with a valid bit. Software-style writes go through a plain address/data port, as with an ordinary RAM. Every stored word has its own equality comparator. A search key is checked against all locations in a single cycle.

A search enters on a valid/ready key stream. The per-location result leaves one clock later on a valid/ready result stream. The result is a vector with one bit per location. A bit is 1 where that location holds a valid word equal to the key. When several locations match, all of their bits are set, and no priority or encoding is applied. An optional summary flag reports whether any bit of the vector is set.

Back-pressure works as follows. The result register holds one result. A new key is accepted only when that register is empty or is being drained in the same cycle. While the result sits unconsumed, `key_ready` stays low and the result stays frozen. With `hit_ready` held high, the block accepts one search per clock.

Top module: `cam_bin`

## Requirements
- R1: While reset is applied and right after it, `hit_valid` is 0, `key_ready` is 1, and every location is invalid.
- R2: A write with `wr_en`=1 stores `wr_data` at location `wr_addr` and marks that location valid from the next clock edge onward.
- R3: Bit i of `hit_vec` is 1 exactly when location i is valid and its stored word equals the search key in every bit.
- R4: When several valid locations hold the key, every one of their bits is set in `hit_vec`.
- R5: A location that has not been written since reset never sets its bit, even for a key equal to its power-up register value (zero).
- R6: With `ENABLE_ANY`=1, `any_hit` equals the OR of all bits of `hit_vec`. With `ENABLE_ANY`=0, `any_hit` is always 0.
- R7: A key accepted at a clock edge (`key_valid` and `key_ready` both 1) produces `hit_valid`=1 with its result right after that same edge, which is one cycle of latency.
- R8: While `hit_valid`=1 and `hit_ready`=0, `key_ready` is 0 and `hit_vec` and `any_hit` hold their values.
- R9: While `hit_ready` is held at 1, `key_ready` stays 1 and back-to-back keys each produce their own result on consecutive cycles.
- R10: A search accepted in the same cycle as a write compares against the contents as they were before that write. The write is seen by the next search.
- R11: Writing an already valid location replaces its old word, so the old word no longer matches there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | $clog2(DEPTH) | Location to write |
| wr_data | input | WIDTH | Word to store |
| key_valid | input | 1 | Search key offered |
| key_ready | output | 1 | Block can take a key this cycle |
| key_data | input | WIDTH | Search key |
| hit_valid | output | 1 | Result register holds a result |
| hit_ready | input | 1 | Consumer takes the result |
| hit_vec | output | DEPTH | One bit per location, 1 = match |
| any_hit | output | 1 | OR of `hit_vec` (0 when disabled) |

## Verification
The bench builds two copies with `DEPTH`=8 and `WIDTH`=8. One has `ENABLE_ANY`=1 and the other has `ENABLE_ANY`=0, so both variants of the summary flag are checked against the same traffic. Eight locations are enough to cover a key held in three places, a location left unwritten, an overwrite, and a write that lands in the same cycle as a search. The bench also stalls the result port to check that results are held and that no keys are accepted during the stall.

// File: rtl/cam_pkg.sv
package cam_pkg;
  // Width of an index into a table of n entries (at least 1 bit).
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cam_store.sv
module cam_store #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int AW = cam_pkg::idx_w(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [WIDTH-1:0]       wr_data,
  output logic [DEPTH-1:0][WIDTH-1:0] words,
  output logic [DEPTH-1:0]       live
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_addr == AW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live[i]  <= 1'b0;
        words[i] <= '0;
      end else if (sel) begin
        live[i]  <= 1'b1;
        words[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/cam_compare.sv
module cam_compare #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  parameter bit ENABLE_ANY = 1'b1
) (
  input  logic [DEPTH-1:0][WIDTH-1:0] words,
  input  logic [DEPTH-1:0]       live,
  input  logic [WIDTH-1:0]       key,
  output logic [DEPTH-1:0]       eq,
  output logic                   any
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic [WIDTH-1:0] diff;
    assign diff  = words[i] ^ key;
    assign eq[i] = live[i] && (diff == '0);
  end
  if (ENABLE_ANY) begin : g_any
    assign any = |eq;
  end else begin : g_no_any
    assign any = 1'b0;
  end
endmodule

// File: rtl/cam_result.sv
module cam_result #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DEPTH-1:0] in_vec,
  input  logic             in_any,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DEPTH-1:0] out_vec,
  output logic             out_any
);
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
      out_any   <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_vec   <= in_vec;
      out_any   <= in_any;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cam_bin.sv
module cam_bin #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  parameter bit ENABLE_ANY = 1'b1,
  localparam int AW = cam_pkg::idx_w(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             key_valid,
  output logic             key_ready,
  input  logic [WIDTH-1:0] key_data,
  output logic             hit_valid,
  input  logic             hit_ready,
  output logic [DEPTH-1:0] hit_vec,
  output logic             any_hit
);
  logic [DEPTH-1:0][WIDTH-1:0] words;
  logic [DEPTH-1:0]            live;
  logic [DEPTH-1:0]            eq;
  logic                        any_c;

  cam_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .words(words), .live(live)
  );

  cam_compare #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ENABLE_ANY(ENABLE_ANY)) u_cmp (
    .words(words), .live(live), .key(key_data), .eq(eq), .any(any_c)
  );

  cam_result #(.DEPTH(DEPTH)) u_res (
    .clk(clk), .rst_n(rst_n), .in_valid(key_valid), .in_ready(key_ready),
    .in_vec(eq), .in_any(any_c), .out_valid(hit_valid), .out_ready(hit_ready),
    .out_vec(hit_vec), .out_any(any_hit)
  );
endmodule

// File: rtl/cam_bin_chk.sv
module cam_bin_chk #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  parameter bit ENABLE_ANY = 1'b1,
  localparam int AW = cam_pkg::idx_w(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic             key_valid,
  input logic             key_ready,
  input logic             hit_valid,
  input logic             hit_ready,
  input logic [DEPTH-1:0] hit_vec,
  input logic             any_hit
);
  // Shadow of locations written since reset, built from the write port only.
  logic [DEPTH-1:0] written;
  always_ff @(posedge clk) begin
    if (!rst_n) written <= '0;
    else if (wr_en) written <= written | (DEPTH'(1) << wr_addr);
  end

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !hit_valid);
  a_r5_no_unwritten_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> ((hit_vec & ~written) == '0));
  a_r6_any_flag: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit == (ENABLE_ANY ? (|hit_vec) : 1'b0));
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && key_ready) |=> hit_valid);
  a_r8_no_accept_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !hit_ready) |-> !key_ready);
  a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !hit_ready) |=> (hit_valid && $stable(hit_vec) && $stable(any_hit)));
endmodule

bind cam_bin cam_bin_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ENABLE_ANY(ENABLE_ANY)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .key_valid(key_valid), .key_ready(key_ready), .hit_valid(hit_valid),
  .hit_ready(hit_ready), .hit_vec(hit_vec), .any_hit(any_hit)
);

// File: tb/tb_cam_bin.sv
module tb_cam_bin;
  localparam int D = 8;
  localparam int W = 8;
  localparam int NV = 8;
  // {key, expected vector} after preload
  localparam logic [15:0] VEC [NV] = '{
    16'h11_01, 16'h22_4A, 16'h33_04, 16'h55_10,
    16'hA0_20, 16'h0F_00, 16'h00_00, 16'h23_00 };

  logic clk = 0, rst_n = 0;
  logic wr_en = 0; logic [2:0] wr_addr = 0; logic [W-1:0] wr_data = 0;
  logic key_valid = 0, hit_ready = 1; logic [W-1:0] key_data = 0;
  logic key_ready, hit_valid, any_hit, key_ready2, hit_valid2, any_hit2;
  logic [D-1:0] hit_vec, hit_vec2;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  cam_bin #(.DEPTH(D), .WIDTH(W), .ENABLE_ANY(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .key_valid(key_valid), .key_ready(key_ready), .key_data(key_data),
    .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_vec(hit_vec), .any_hit(any_hit));
  cam_bin #(.DEPTH(D), .WIDTH(W), .ENABLE_ANY(1'b0)) dut_noany (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .key_valid(key_valid), .key_ready(key_ready2), .key_data(key_data),
    .hit_valid(hit_valid2), .hit_ready(hit_ready), .hit_vec(hit_vec2), .any_hit(any_hit2));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  // One search, result sampled at the negedge after the accepting edge.
  task automatic search(input string req, input logic [W-1:0] k, input logic [D-1:0] exp);
    @(negedge clk); key_valid = 1; key_data = k;
    @(negedge clk); key_valid = 0;
    chk({req, " valid"}, 32'(hit_valid), 1);
    chk(req, 32'(hit_vec), 32'(exp));
    chk({req, " any R6"}, 32'(any_hit), 32'(exp != 0));
    chk({req, " R6 no-any copy"}, {hit_vec2, any_hit2}, {exp, 1'b0});
  endtask

  initial begin : watchdog
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 hit_valid in reset", 32'(hit_valid), 0);
    chk("R1 key_ready in reset", 32'(key_ready), 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 hit_valid after reset", 32'(hit_valid), 0);
    // R5: nothing written yet, key equals power-up zero
    search("R5 unwritten zero key", 8'h00, 8'h00);
    @(negedge clk);
    chk("R7 valid drops when drained", 32'(hit_valid), 0);

    // R2 preload: locations 0..6, location 7 left unwritten
    wr(0, 8'h11); wr(1, 8'h22); wr(2, 8'h33); wr(3, 8'h22);
    wr(4, 8'h55); wr(5, 8'hA0); wr(6, 8'h22);
    for (int i = 0; i < NV; i++) begin
      // R3 exact match, R4 multiple hits (key 22), R5 location 7
      search("R3/R4 table", VEC[i][15:8], VEC[i][7:0]);
    end

    // R10: write location 7 with 11 in the same cycle as a search for 11
    @(negedge clk); wr_en = 1; wr_addr = 3'd7; wr_data = 8'h11;
    key_valid = 1; key_data = 8'h11;
    @(negedge clk); wr_en = 0; key_valid = 0;
    chk("R10 same-cycle write unseen", 32'(hit_vec), 32'h01);
    search("R10 write seen next", 8'h11, 8'h81);

    // R11 overwrite location 0
    wr(0, 8'h77);
    search("R11 old word gone", 8'h11, 8'h80);
    search("R11 new word", 8'h77, 8'h01);

    // R9 back-to-back: two keys on consecutive cycles
    @(negedge clk); key_valid = 1; key_data = 8'h22;
    @(negedge clk); key_data = 8'h55;
    chk("R9 ready during stream", 32'(key_ready), 1);
    chk("R9 first result", 32'(hit_vec), 32'h4A);
    @(negedge clk); key_valid = 0;
    chk("R9 second result", 32'(hit_vec), 32'h10);
    chk("R9 second valid", 32'(hit_valid), 1);

    // R8 back-pressure
    @(negedge clk); hit_ready = 0; key_valid = 1; key_data = 8'h33;
    @(negedge clk); key_data = 8'h22;
    chk("R8 key_ready low", 32'(key_ready), 0);
    chk("R8 vec captured", 32'(hit_vec), 32'h04);
    @(negedge clk);
    chk("R8 vec held", 32'(hit_vec), 32'h04);
    chk("R8 valid held", 32'(hit_valid), 1);
    key_valid = 0; hit_ready = 1;
    @(negedge clk);
    chk("R8 drained", 32'(hit_valid), 0);
    chk("R8 blocked key not taken", 32'(hit_vec), 32'h04);

    // R1 reset again invalidates everything
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    search("R1 contents cleared", 8'h22, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule